// File: doc/BRIEF.md
# Wiper Position Counter with Step Mode

This block keeps the 6-bit tap position of one digitally controlled resistor ladder and drives the switch enables for its 64 tap nodes. The ladder has 63 series segments. Position 63 is the top end of the ladder and position 0 is the bottom end. Exactly one switch is closed on every cycle.

The position changes in two ways. A parallel load writes a new code, either from a host write or from a register transfer. A step request moves the position by one tap while the serial frame is in increment/decrement mode. The upstream frame logic turns each serial clock high pulse into a one-cycle `step_pulse` and samples the data line into `step_up`. Step mode has no fixed length: `step_mode` stays high until the frame ends.

A parallel load shows up on `code_o` at once. The tap switches follow only after a settle delay, which models the slow analog response of the wiper. A single step drives the switches on the next cycle.

Top module: `wiper_tap_ctrl`

## Requirements
- R1: `tap_sel_o` bit i is the only bit set when the applied position is i (bit 0 is the bottom end, bit 63 the top end), with a 6-bit code.
- R2: On every cycle out of reset, exactly one bit of `tap_sel_o` is set.
- R3: While `rst_n` is low at a rising edge (synchronous, active low), `code_o` becomes RESET_CODE (default 0), the pending settle delay is cleared, and `tap_sel_o` selects the same RESET_CODE (default bit 0).
- R4: A rising edge with `load_valid` high sets `code_o` to `load_code`.
- R5: After a load edge, `tap_sel_o` keeps its previous value for SETTLE_CYCLES (default 4) further edges and changes to the new position at the next edge after those. A load that arrives during this wait restarts the wait.
- R6: In step mode (`step_mode`=1, `step_pulse`=1, `load_valid`=0), `step_up`=1 raises `code_o` by one.
- R7: In step mode, `step_up`=0 lowers `code_o` by one.
- R8: A step up at 63 or a step down at 0 leaves `code_o` unchanged. The code does not wrap.
- R9: When `load_valid` and a step request are high in the same cycle, the load value is taken and the step is dropped.
- R10: A step request is ignored when `step_mode` is low or `step_pulse` is low. In that case `code_o` and `tap_sel_o` stay unchanged.
- R11: When no settle wait is pending, `tap_sel_o` follows a step one edge after `code_o` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_valid | input | 1 | Parallel load strobe |
| load_code | input | 6 | Position to load |
| step_mode | input | 1 | Increment/decrement mode active |
| step_pulse | input | 1 | One-cycle strobe per serial clock high pulse |
| step_up | input | 1 | Data line level during the pulse: 1 = toward top end |
| code_o | output | 6 | Current position code |
| tap_sel_o | output | 64 | One-hot tap switch enables |

## Verification
The hardest case to reach from the ports is a load, or a step, that lands while the settle wait from an earlier load is still counting down. During that time `code_o` and `tap_sel_o` disagree. The stimulus issues a second load a few cycles into the wait to check that the wait restarts. It also steps right after a load to check that the old switch stays selected until the wait expires. The saturation corners are reached by loading 60 and 3 and then stepping past the ends.

// File: rtl/wiper_pkg.sv
// Shared types for the wiper position counter.
// Assumes: one step request per cycle at most.
package wiper_pkg;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } step_dir_e;

    typedef struct packed {
        logic      valid;
        step_dir_e dir;
    } step_req_t;
endpackage

// File: rtl/wiper_pos_reg.sv
// Position register: parallel load has priority over a single saturating step.
// Assumes: step request already qualified by step mode; at most one move per cycle.
module wiper_pos_reg
    import wiper_pkg::*;
#(
    parameter int CODE_W     = 6,
    parameter int RESET_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [CODE_W-1:0] load_code,
    input  step_req_t         step_req,
    output logic [CODE_W-1:0] pos_o
);
    localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] BOT = '0;

    logic [CODE_W-1:0] pos_q;
    logic [CODE_W-1:0] stepped;

    // Compute the saturated neighbour position for a step.
    always_comb begin
        stepped = pos_q;
        if (step_req.dir == DIR_UP) begin
            if (pos_q != TOP) stepped = pos_q + 1'b1;
        end else begin
            if (pos_q != BOT) stepped = pos_q - 1'b1;
        end
    end

    // Hold the position; load wins over a step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= CODE_W'(RESET_CODE);
        else if (load_valid)
            pos_q <= load_code;
        else if (step_req.valid)
            pos_q <= stepped;
    end

    assign pos_o = pos_q;
endmodule

// File: rtl/wiper_settle_stage.sv
// Applied-position register with a response delay after each parallel load.
// Assumes: the target position comes from wiper_pos_reg; steps apply with no wait.
module wiper_settle_stage #(
    parameter int CODE_W        = 6,
    parameter int SETTLE_CYCLES = 4,
    parameter int RESET_CODE    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [CODE_W-1:0] target,
    output logic [CODE_W-1:0] applied_o
);
    localparam int CNT_W = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(SETTLE_CYCLES);

    logic [CNT_W-1:0]  wait_q;
    logic [CODE_W-1:0] applied_q;

    // Count down the remaining response delay; a load restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wait_q <= '0;
        else if (load_valid)
            wait_q <= WAIT_LOAD;
        else if (wait_q != '0)
            wait_q <= wait_q - 1'b1;
    end

    // Copy the target into the applied position only once no wait is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)
            applied_q <= CODE_W'(RESET_CODE);
        else if (wait_q == '0)
            applied_q <= target;
    end

    assign applied_o = applied_q;
endmodule

// File: rtl/wiper_tap_decode.sv
// Binary to one-hot tap switch decoder.
// Assumes: every code value maps to a tap, so the output is always one-hot.
module wiper_tap_decode #(
    parameter int CODE_W = 6
) (
    input  logic [CODE_W-1:0]        code,
    output logic [(1<<CODE_W)-1:0]   onehot
);
    localparam int TAPS = 1 << CODE_W;

    // One comparator per tap switch.
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign onehot[i] = (code == CODE_W'(i));
    end
endmodule

// File: rtl/wiper_tap_ctrl.sv
// Top: wiper position counter with step mode and a settled one-hot tap select.
// Assumes: step_pulse is a single-cycle strobe from the frame logic, step_up
// is the sampled data line, and step_mode covers the whole step frame.
module wiper_tap_ctrl
    import wiper_pkg::*;
#(
    parameter int CODE_W        = 6,
    parameter int SETTLE_CYCLES = 4,
    parameter int RESET_CODE    = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_valid,
    input  logic [CODE_W-1:0]       load_code,
    input  logic                    step_mode,
    input  logic                    step_pulse,
    input  logic                    step_up,
    output logic [CODE_W-1:0]       code_o,
    output logic [(1<<CODE_W)-1:0]  tap_sel_o
);
    step_req_t         req;
    logic [CODE_W-1:0] pos;
    logic [CODE_W-1:0] applied;

    // Qualify the step strobe with the step mode.
    always_comb begin
        req.valid = step_mode && step_pulse;
        req.dir   = step_up ? DIR_UP : DIR_DOWN;
    end

    wiper_pos_reg #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_pos (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid),
        .load_code(load_code), .step_req(req), .pos_o(pos)
    );

    wiper_settle_stage #(.CODE_W(CODE_W), .SETTLE_CYCLES(SETTLE_CYCLES),
                         .RESET_CODE(RESET_CODE)) u_settle (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid),
        .target(pos), .applied_o(applied)
    );

    wiper_tap_decode #(.CODE_W(CODE_W)) u_dec (
        .code(applied), .onehot(tap_sel_o)
    );

    assign code_o = pos;
endmodule

// File: rtl/wiper_tap_ctrl_checker.sv
// Assertions for wiper_tap_ctrl, attached by bind.
// Assumes: the parameters match the bound instance.
module wiper_tap_ctrl_checker #(
    parameter int CODE_W        = 6,
    parameter int SETTLE_CYCLES = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    load_valid,
    input logic [CODE_W-1:0]       load_code,
    input logic                    step_mode,
    input logic                    step_pulse,
    input logic                    step_up,
    input logic [CODE_W-1:0]       code_o,
    input logic [(1<<CODE_W)-1:0]  tap_sel_o
);
    localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};
    localparam int WIN_W = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1);

    logic [WIN_W-1:0] win_q;
    logic             step_ok;

    assign step_ok = !load_valid && step_mode && step_pulse;

    // Window counter covering the cycles in which the taps must hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_q <= '0;
        else if (load_valid)
            win_q <= WIN_W'(SETTLE_CYCLES);
        else if (win_q != '0)
            win_q <= win_q - 1'b1;
    end

    assert_one_tap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel_o) == 1);

    assert_load_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> code_o == $past(load_code));

    assert_settle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q != '0) |=> $stable(tap_sel_o));

    assert_step_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && step_up && code_o != TOP) |=> code_o == $past(code_o) + 1'b1);

    assert_step_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && !step_up && code_o != '0) |=> code_o == $past(code_o) - 1'b1);

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && ((step_up && code_o == TOP) || (!step_up && code_o == '0)))
        |=> $stable(code_o));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_valid && !(step_mode && step_pulse)) |=> $stable(code_o));
endmodule

bind wiper_tap_ctrl wiper_tap_ctrl_checker #(
    .CODE_W(CODE_W), .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_code(load_code),
    .step_mode(step_mode), .step_pulse(step_pulse), .step_up(step_up),
    .code_o(code_o), .tap_sel_o(tap_sel_o)
);

// File: tb/sim_wiper_tap_ctrl.sv
module sim_wiper_tap_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CW   = 6;
    localparam int S    = 4;
    localparam int TAPS = 1 << CW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            load_valid = 1'b0;
    logic [CW-1:0]   load_code = '0;
    logic            step_mode = 1'b0;
    logic            step_pulse = 1'b0;
    logic            step_up = 1'b0;
    logic [CW-1:0]   code_o;
    logic [TAPS-1:0] tap_sel_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int exp_code  = 0;
    int exp_shown = 0;
    int exp_wait  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_tap_ctrl #(.CODE_W(CW), .SETTLE_CYCLES(S), .RESET_CODE(0)) u0 (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_code(load_code),
        .step_mode(step_mode), .step_pulse(step_pulse), .step_up(step_up),
        .code_o(code_o), .tap_sel_o(tap_sel_o)
    );

    task automatic chk(input string tag, input logic [TAPS-1:0] act,
                       input logic [TAPS-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        chk({tag, " code"}, TAPS'(code_o), TAPS'(exp_code));
        chk({tag, " tap"}, tap_sel_o, TAPS'(1) << exp_shown);
        chk("R2 one tap", TAPS'($countones(tap_sel_o)), TAPS'(1));
    endtask

    // One clock with given inputs; the bench model advances per the requirements.
    task automatic cyc(input bit ld, input int lc, input bit md, input bit pl,
                       input bit up, input string tag);
        int nc;
        load_valid = ld; load_code = CW'(lc);
        step_mode = md; step_pulse = pl; step_up = up;
        @(posedge clk);
        #1;
        nc = exp_code;
        if (ld) nc = lc;
        else if (md && pl) begin
            if (up && exp_code < TAPS-1) nc = exp_code + 1;
            if (!up && exp_code > 0) nc = exp_code - 1;
        end
        if (exp_wait == 0) exp_shown = exp_code;
        exp_wait = ld ? S : (exp_wait > 0 ? exp_wait - 1 : 0);
        exp_code = nc;
        load_valid = 0; step_pulse = 0;
        check_outputs(tag);
    endtask

    task automatic settle(input string tag);
        for (int i = 0; i < S + 1; i++) cyc(0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1;
        exp_code = 0; exp_shown = 0; exp_wait = 0;
        check_outputs("R3 reset");
        rst_n = 1;

        // R1 R4 R5: every code, tap holds S edges then switches.
        for (int c = TAPS - 1; c >= 0; c--) begin
            cyc(1, c, 0, 0, 0, "R4 load");
            for (int k = 0; k < S; k++) cyc(0, 0, 0, 0, 0, "R5 hold");
            cyc(0, 0, 0, 0, 0, "R1 tap position");
        end

        // R6 R8: climb to the top and past it.
        cyc(1, 60, 0, 0, 0, "R4 load");
        settle("R5 settle");
        for (int k = 0; k < 6; k++) cyc(0, 0, 1, 1, 1, "R6 R8 step up");
        cyc(0, 0, 0, 0, 0, "R11 follow");

        // R7 R8: descend to the bottom and past it.
        cyc(1, 3, 0, 0, 0, "R4 load");
        settle("R5 settle");
        for (int k = 0; k < 6; k++) cyc(0, 0, 1, 1, 0, "R7 R8 step down");
        cyc(0, 0, 0, 0, 0, "R11 follow");

        // R10: pulses outside step mode, step mode without pulses.
        cyc(1, 30, 0, 0, 0, "R4 load");
        settle("R5 settle");
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 1, 1, "R10 mode off");
        for (int k = 0; k < 3; k++) cyc(0, 0, 1, 0, 1, "R10 no pulse");

        // R9: load and step together.
        cyc(1, 10, 1, 1, 1, "R9 load wins");
        cyc(1, 50, 1, 1, 0, "R9 load wins");
        settle("R5 settle");

        // R11: each step shows on the taps one edge later.
        for (int k = 0; k < 4; k++) cyc(0, 0, 1, 1, k[0], "R11 step follow");
        cyc(0, 0, 0, 0, 0, "R11 follow");

        // R5: restart of the wait, and steps inside the wait.
        cyc(1, 20, 0, 0, 0, "R4 load");
        cyc(0, 0, 0, 0, 0, "R5 hold");
        cyc(0, 0, 1, 1, 1, "R5 step in wait");
        cyc(1, 40, 0, 0, 0, "R5 restart");
        for (int k = 0; k < S; k++) cyc(0, 0, 1, 1, 0, "R5 hold restart");
        settle("R5 settle after restart");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule